// File: doc/BRIEF.md
# I2C Port Expander Register Slave

This block is the digital core of an 8-bit port expander that sits on a two-wire serial bus. A host addresses it, writes a command byte that acts as a register pointer, and then writes or reads one of four byte-wide registers: a snapshot of the pins, the output latch, a per-pin polarity inverter and a per-pin direction mask. The direction and output registers drive the pad logic. The polarity-corrected pin levels are brought out as a live vector.

SCL and SDA arrive already filtered and synchronous to the system clock, and the block samples them once per clock. The slave pulls SDA low through a single enable output. The bus is serial, so it has no valid/ready stream: every transfer is paced by the master's SCL. The slave gives no back-pressure and never stretches the clock. All other pins are plain levels.

Top module: `gxp_expander`

## Requirements
- R1: The slave answers only the 7-bit address 0b010000 followed by the `addr_sel_i` level (0x20 or 0x21). It drives ACK low in the ninth clock of a matching address byte and never pulls SDA for any other address.
- R2: Bit 0 of the address byte selects the direction (1 = read, 0 = write). The slave asserts its SDA pull only while SCL is low.
- R3: The first byte after a write address is the pointer: 0x00 selects the pin snapshot, 0x01 the output latch, 0x02 the polarity mask and 0x03 the direction mask. Each of these reads back the value last written to it.
- R4: After reset the output latch is 0xFF, the polarity mask is 0x00 and the direction mask is 0xFF, so every pin is an input.
- R5: A read of pointer 0x00 returns the pin levels XORed bitwise with the polarity mask, whatever each pin's direction. Writes to pointer 0x00 change no register.
- R6: `pin_dir_o` equals the direction mask (1 = input, 0 = driven output) and `pin_out_o` equals the output latch. A read of pointer 0x01 returns the latch, not the pin levels.
- R7: Read data leaves MSB first. A NACK from the master ends the read and releases SDA, and a STOP may then follow.
- R8: Every data byte of a multi-byte write goes to the register the pointer selected. The pointer does not advance, so the last byte written is the one that remains.
- R9: The pin snapshot is taken on the SCL rising edge of every ACK clock in a read. Each byte of a read burst from pointer 0x00 therefore reflects the pins at the preceding ACK clock.
- R10: Driving `rst_n` low at any time, even in the middle of a transfer, restores the R4 defaults and releases SDA.
- R11: Pointer values above 0x03 are acknowledged. Writes through them are discarded, and reads through them return 0x00.
- R12: A START or STOP at any bit position abandons the byte in progress without writing it. After a START the slave waits for an address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Filtered, synchronous SCL level |
| sda_i | input | 1 | Filtered, synchronous SDA level (wired-AND bus) |
| addr_sel_i | input | 1 | Address LSB select |
| pin_i | input | 8 | Levels seen on the port pins |
| sda_pull_o | output | 1 | 1 = pull SDA low |
| pin_dir_o | output | 8 | Per-pin direction, 1 = input |
| pin_out_o | output | 8 | Output latch driven onto output pins |
| in_val_o | output | 8 | Live pin levels after polarity correction |

## Verification
A register write lands at the clock edge that first sees SCL low after the eighth data bit, so `pin_dir_o` and `pin_out_o` are due one clock later. The bench reads them only after the whole transfer and its STOP. A read bit appears on SDA one clock after the SCL falling edge, and the bench samples it in the middle of the SCL-high half, several clocks later. The snapshot follows the same rule: the bench changes the pins before the ACK clock rises and expects the new value in the next byte, never in the current one. `in_val_o` is combinational from the pins and the polarity mask, and the bench checks it after the inputs have settled.

// File: rtl/gxp_pkg.sv
package gxp_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_AACK, S_CMD, S_CACK,
    S_WDAT, S_WACK, S_RDAT, S_MACK, S_IGN
  } bus_st_t;

  localparam logic [BYTE_W-1:0] OUT_RST = 8'hFF;
  localparam logic [BYTE_W-1:0] POL_RST = 8'h00;
  localparam logic [BYTE_W-1:0] DIR_RST = 8'hFF;

  function automatic logic [BYTE_W-1:0] reg_rst(input int idx);
    case (idx)
      1:       return OUT_RST;
      2:       return POL_RST;
      default: return DIR_RST;
    endcase
  endfunction
endpackage

// File: rtl/gxp_line_cond.sv
module gxp_line_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_lvl <= 1'b1;
      sda_q   <= 1'b1;
    end else begin
      scl_lvl <= scl_i;
      sda_q   <= sda_i;
    end
  end

  assign scl_rise  =  scl_i & ~scl_lvl;
  assign scl_fall  = ~scl_i &  scl_lvl;
  assign start_det =  scl_i &  scl_lvl &  sda_q & ~sda_i;
  assign stop_det  =  scl_i &  scl_lvl & ~sda_q &  sda_i;
endmodule

// File: rtl/gxp_bus_ctl.sv
module gxp_bus_ctl
  import gxp_pkg::*;
#(
  parameter logic [5:0] ADDR_HI = 6'b010000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              sda_pull_o,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [BYTE_W-1:0] ptr,
  output logic              snap_en
);
  localparam int unsigned CW = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] FULL = CW'(BYTE_W);

  bus_st_t           st;
  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic              rw;
  logic              m_ack;

  assign snap_en = scl_rise && ((st == S_AACK && rw) || st == S_MACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      cnt        <= '0;
      sh         <= '0;
      rw         <= 1'b0;
      m_ack      <= 1'b0;
      sda_pull_o <= 1'b0;
      wr_en      <= 1'b0;
      wr_data    <= '0;
      ptr        <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        st         <= S_ADDR;
        cnt        <= '0;
        sda_pull_o <= 1'b0;
      end else if (stop_det) begin
        st         <= S_IDLE;
        sda_pull_o <= 1'b0;
      end else begin
        case (st)
          S_ADDR, S_CMD, S_WDAT: begin
            if (scl_rise && cnt < FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_i};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              cnt <= '0;
              if (st == S_ADDR) begin
                if (sh[BYTE_W-1:1] == {ADDR_HI, addr_sel_i}) begin
                  rw         <= sh[0];
                  sda_pull_o <= 1'b1;
                  st         <= S_AACK;
                end else begin
                  st <= S_IGN;
                end
              end else if (st == S_CMD) begin
                ptr        <= sh;
                sda_pull_o <= 1'b1;
                st         <= S_CACK;
              end else begin
                wr_en      <= 1'b1;
                wr_data    <= sh;
                sda_pull_o <= 1'b1;
                st         <= S_WACK;
              end
            end
          end
          S_AACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (rw) begin
                sh         <= rd_byte;
                sda_pull_o <= ~rd_byte[BYTE_W-1];
                st         <= S_RDAT;
              end else begin
                sda_pull_o <= 1'b0;
                st         <= S_CMD;
              end
            end
          end
          S_CACK, S_WACK: begin
            if (scl_fall) begin
              sda_pull_o <= 1'b0;
              st         <= S_WDAT;
            end
          end
          S_RDAT: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (scl_fall) begin
              if (cnt == FULL) begin
                sda_pull_o <= 1'b0;
                st         <= S_MACK;
              end else begin
                sh         <= {sh[BYTE_W-2:0], 1'b0};
                sda_pull_o <= ~sh[BYTE_W-2];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) begin
              m_ack <= ~sda_i;
            end else if (scl_fall) begin
              cnt <= '0;
              if (m_ack) begin
                sh         <= rd_byte;
                sda_pull_o <= ~rd_byte[BYTE_W-1];
                st         <= S_RDAT;
              end else begin
                st <= S_IGN;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R2: the slave never starts pulling SDA while SCL is high
  p_pull_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_lvl);
  // R1: an unaddressed slave leaves SDA alone
  p_ign_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |-> !sda_pull_o);
  // R12: a START always returns the slave to address reception
  p_start_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == S_ADDR));
  // R12: a STOP always ends the transfer
  p_stop_abort_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && !start_det) |=> (st == S_IDLE));
  // R8: the pointer changes only when a command byte completes
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $changed(ptr) |-> ($past(st) == S_CMD));
endmodule

// File: rtl/gxp_regs.sv
module gxp_regs
  import gxp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [BYTE_W-1:0] ptr,
  input  logic              snap_en,
  input  logic [BYTE_W-1:0] pin_i,
  output logic [BYTE_W-1:0] out_q,
  output logic [BYTE_W-1:0] pol_q,
  output logic [BYTE_W-1:0] dir_q,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int unsigned IW = $clog2(NUM_REGS);
  localparam logic [BYTE_W-1:0] NREG = BYTE_W'(NUM_REGS);

  logic [NUM_REGS-1:0][BYTE_W-1:0] rf;
  logic [BYTE_W-1:0]               snap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       snap <= '0;
    else if (snap_en) snap <= pin_i ^ pol_q;
  end
  assign rf[0] = snap;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             q <= reg_rst(i);
      else if (wr_en && ptr == BYTE_W'(i))    q <= wr_data;
    end
    assign rf[i] = q;
  end

  assign out_q   = rf[1];
  assign pol_q   = rf[2];
  assign dir_q   = rf[3];
  assign rd_byte = (ptr < NREG) ? rf[ptr[IW-1:0]] : '0;

  // R5: a write through pointer 0 leaves the writable registers unchanged
  p_in_wr_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr == '0) |=> $stable(rf[NUM_REGS-1:1]));
  // R11: a write through an unused pointer leaves every register unchanged
  p_bad_ptr_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr >= NREG) |=> $stable(rf[NUM_REGS-1:1]));
  // R11: an unused pointer reads as zero
  p_bad_ptr_rd_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr >= NREG) |-> (rd_byte == '0));
endmodule

// File: rtl/gxp_expander.sv
module gxp_expander
  import gxp_pkg::*;
#(
  parameter logic [5:0]  ADDR_HI  = 6'b010000,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              addr_sel_i,
  input  logic [BYTE_W-1:0] pin_i,
  output logic              sda_pull_o,
  output logic [BYTE_W-1:0] pin_dir_o,
  output logic [BYTE_W-1:0] pin_out_o,
  output logic [BYTE_W-1:0] in_val_o
);
  logic scl_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en, snap_en;
  logic [BYTE_W-1:0] wr_data, ptr, rd_byte, pol_q;

  gxp_line_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  gxp_bus_ctl #(.ADDR_HI(ADDR_HI)) u_ctl (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .sda_i(sda_i), .addr_sel_i(addr_sel_i), .rd_byte(rd_byte),
    .sda_pull_o(sda_pull_o), .wr_en(wr_en), .wr_data(wr_data),
    .ptr(ptr), .snap_en(snap_en)
  );

  gxp_regs #(.NUM_REGS(NUM_REGS)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .ptr(ptr), .snap_en(snap_en), .pin_i(pin_i),
    .out_q(pin_out_o), .pol_q(pol_q), .dir_q(pin_dir_o), .rd_byte(rd_byte)
  );

  assign in_val_o = pin_i ^ pol_q;
endmodule

// File: tb/sim_gxp_expander.sv
`timescale 1ns/1ps
module sim_gxp_expander;
  localparam int H = 4;
  localparam int NV = 12;
  // entry: {op[1:0] (0 write, 1 read), cmd[7:0], wdata[7:0], pins[7:0], expect[7:0]}
  localparam logic [33:0] VEC [NV] = '{
    {2'd0, 8'h02, 8'hF0, 8'h00, 8'h00},
    {2'd1, 8'h02, 8'h00, 8'h00, 8'hF0},
    {2'd1, 8'h00, 8'h00, 8'h3C, 8'hCC},
    {2'd0, 8'h03, 8'h0F, 8'h3C, 8'h00},
    {2'd1, 8'h03, 8'h00, 8'h3C, 8'h0F},
    {2'd0, 8'h01, 8'hA5, 8'h3C, 8'h00},
    {2'd1, 8'h01, 8'h00, 8'h3C, 8'hA5},
    {2'd0, 8'h00, 8'h00, 8'h3C, 8'h00},
    {2'd1, 8'h00, 8'h00, 8'h81, 8'h71},
    {2'd1, 8'h01, 8'h00, 8'h81, 8'hA5},
    {2'd0, 8'h02, 8'h00, 8'h81, 8'h00},
    {2'd1, 8'h00, 8'h00, 8'h96, 8'h96}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic addr_sel = 1'b0;
  logic [7:0] pins = 8'h00;
  logic sda_pull;
  logic [7:0] pin_dir, pin_out, in_val;
  logic sda_line;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  gxp_expander u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .addr_sel_i(addr_sel), .pin_i(pins), .sda_pull_o(sda_pull),
    .pin_dir_o(pin_dir), .pin_out_o(pin_out), .in_val_o(in_val)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic half();
    repeat (H) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; half(); scl = 1'b1; half(); sda_m = 1'b0; half(); scl = 1'b0; half();
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; half(); scl = 1'b1; half(); sda_m = 1'b1; half();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; half(); scl = 1'b1; half(); scl = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) wbit(b[i]);
    sda_m = 1'b1; half(); scl = 1'b1; repeat (H/2) @(negedge clk);
    ack = ~sda_line; repeat (H - H/2) @(negedge clk); scl = 1'b0;
  endtask

  task automatic rbyte(input logic mack, input logic [7:0] nxt, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; half(); scl = 1'b1; repeat (H/2) @(negedge clk);
      d[i] = sda_line; repeat (H - H/2) @(negedge clk); scl = 1'b0;
    end
    pins = nxt;
    sda_m = ~mack; half(); scl = 1'b1; half(); scl = 1'b0;
  endtask

  task automatic wr_reg(input logic [7:0] cmd, input logic [7:0] v, output logic ok);
    logic a1, a2, a3;
    i2c_start(); wbyte({6'b010000, addr_sel, 1'b0}, a1); wbyte(cmd, a2); wbyte(v, a3); i2c_stop();
    ok = a1 & a2 & a3;
  endtask

  task automatic rd_reg(input logic [7:0] cmd, output logic [7:0] d, output logic ok);
    logic a1, a2, a3;
    i2c_start(); wbyte({6'b010000, addr_sel, 1'b0}, a1); wbyte(cmd, a2);
    i2c_start(); wbyte({6'b010000, addr_sel, 1'b1}, a3); rbyte(1'b0, pins, d); i2c_stop();
    ok = a1 & a2 & a3;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic ok, a;
    logic [7:0] d, d2, d3;
    repeat (4) @(negedge clk);
    // R4: defaults after reset (checked while reset is still applied)
    check("R4 dir reset", pin_dir, 8'hFF);
    check("R4 out reset", pin_out, 8'hFF);
    check("R4 pull released", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_reg(8'h02, d, ok);
    check("R4 polarity reset", d, 8'h00);
    check("R1 ack own address", {7'd0, ok}, 8'h01);

    // R3 R5 table of register writes and reads
    for (int k = 0; k < NV; k++) begin
      pins = VEC[k][15:8];
      half();
      if (VEC[k][33:32] == 2'd0) begin
        wr_reg(VEC[k][31:24], VEC[k][23:16], ok);
        check(VEC[k][31:24] == 8'h00 ? "R5 write to input acked" : "R3 write acked", {7'd0, ok}, 8'h01);
      end else begin
        rd_reg(VEC[k][31:24], d, ok);
        check(VEC[k][31:24] == 8'h00 ? "R5 input read" : "R3 register read", d, VEC[k][7:0]);
      end
    end
    check("R5 live polarity vector", in_val, 8'h96);

    // R6: output latch reads back regardless of pins
    wr_reg(8'h03, 8'h00, ok);
    wr_reg(8'h01, 8'h5A, ok);
    pins = 8'hFF; half();
    check("R6 dir port", pin_dir, 8'h00);
    check("R6 out port", pin_out, 8'h5A);
    rd_reg(8'h01, d, ok);
    check("R6 latch readback", d, 8'h5A);
    rd_reg(8'h00, d, ok);
    check("R5 input regardless of direction", d, 8'hFF);

    // R1: other address not acknowledged, then select pin moves address
    i2c_start(); wbyte(8'h42, a); i2c_stop();
    check("R1 foreign address nack", {7'd0, a}, 8'h00);
    addr_sel = 1'b1;
    wr_reg(8'h01, 8'h3E, ok);
    check("R1 address 0x21 acked", {7'd0, ok}, 8'h01);
    check("R1 write via 0x21", pin_out, 8'h3E);
    addr_sel = 1'b0;

    // R8: burst write stays on the pointer
    i2c_start(); wbyte(8'h40, a); wbyte(8'h01, a);
    wbyte(8'h11, a); wbyte(8'h22, a); wbyte(8'h33, a); i2c_stop();
    check("R8 burst last byte", pin_out, 8'h33);
    check("R8 dir untouched", pin_dir, 8'h00);

    // R9 R7: burst read of pin snapshot re-samples at each ack clock
    pins = 8'hA1; half();
    i2c_start(); wbyte(8'h40, a); wbyte(8'h00, a);
    i2c_start(); wbyte(8'h41, a);
    rbyte(1'b1, 8'hB2, d); rbyte(1'b1, 8'hC3, d2); rbyte(1'b0, 8'hC3, d3); i2c_stop();
    check("R9 first byte", d, 8'hA1);
    check("R9 second byte", d2, 8'hB2);
    check("R9 third byte", d3, 8'hC3);
    check("R7 sda released after nack", {7'd0, sda_pull}, 8'h00);

    // R11: unused pointer
    wr_reg(8'h07, 8'h00, ok);
    check("R11 unused pointer acked", {7'd0, ok}, 8'h01);
    check("R11 write discarded out", pin_out, 8'h33);
    check("R11 write discarded dir", pin_dir, 8'h00);
    rd_reg(8'h07, d, ok);
    check("R11 unused pointer reads zero", d, 8'h00);

    // R12: START mid-byte, then STOP mid-byte
    i2c_start(); wbyte(8'h40, a); wbyte(8'h01, a);
    wbit(1'b0); wbit(1'b0); wbit(1'b0); wbit(1'b0);
    i2c_start(); wbyte(8'h40, a);
    check("R12 address after restart acked", {7'd0, a}, 8'h01);
    wbyte(8'h03, a); wbyte(8'hC0, a); i2c_stop();
    check("R12 restart keeps out", pin_out, 8'h33);
    check("R12 write after restart", pin_dir, 8'hC0);
    i2c_start(); wbyte(8'h40, a); wbyte(8'h01, a);
    wbit(1'b1); wbit(1'b0); wbit(1'b1);
    i2c_stop();
    check("R12 stop abandons byte", pin_out, 8'h33);

    // R10: reset in the middle of a transfer
    i2c_start(); wbyte(8'h40, a); wbyte(8'h01, a);
    wbit(1'b0); wbit(1'b1);
    rst_n = 1'b0; repeat (3) @(negedge clk);
    check("R10 out default", pin_out, 8'hFF);
    check("R10 dir default", pin_dir, 8'hFF);
    check("R10 pull released", {7'd0, sda_pull}, 8'h00);
    rst_n = 1'b1; repeat (2) @(negedge clk);
    i2c_stop();
    rd_reg(8'h01, d, ok);
    check("R10 out readback after reset", d, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule